// File: doc/BRIEF.md
# Auto-Acknowledge Receive Sequencer

This block is the control sequencer of a packet radio receiver that answers frames with an acknowledgment on its own. It sits in a listening state until the modem reports a start-of-frame delimiter, then holds a busy-receive state until the modem reports the end of the frame. At that point it raises a one-cycle receive-end interrupt. If the frame asked for an acknowledgment and is of a kind that may be acknowledged, the block turns the radio around to transmit.

The turnaround is timed in symbol periods. A prescaler divides the system clock into symbol ticks, and a down-counter counts either the long default wait or the short wait chosen by a configuration bit. In slotted mode no timer is used. The block waits for a rising edge on a host-driven trigger pin and reports that it is waiting through its status code.

While the acknowledgment is sent, the direction output stays in transmit for a fixed number of symbols. When that ends, a transmit-end interrupt is raised and the block listens again. Modem, CRC checking and frame assembly live outside.

Top module: `ack_rx_sequencer`

## Requirements
- R1: A cycle with `sfd_det` high while listening makes `rx_busy` high from the next cycle until the frame ends.
- R2: `frame_end` sampled high while busy gives a one-cycle `irq_rx_end` pulse in the next cycle; `frame_end` while listening gives no pulse.
- R3: An acknowledgment is sent only if `ack_req` is 1 and `frame_type` is 3'b001 (data) or 3'b011 (command); otherwise the block returns to listening with `tx_dir` and `ack_start` held low.
- R4: With `short_tat` = 0 and `slotted` = 0, `ack_start` goes high exactly LONG_SYMS×CYC_PER_SYM cycles after the edge that sampled `frame_end` (12×16 = 192 by default).
- R5: With `short_tat` = 1 and `slotted` = 0, that delay is SHORT_SYMS×CYC_PER_SYM cycles (2×16 = 32 by default).
- R6: With `slotted` = 1, no acknowledgment starts until a rising edge on `slp_tr`; `ack_start` then goes high in the cycle after the edge that samples the rise.
- R7: While a slotted acknowledgment waits for its trigger, `status` is 3'd1; once the trigger is taken, `status` is 3'd0.
- R8: A rising edge on `slp_tr` outside the slotted wait sets `status` to 3'd7, which holds until the next accepted start-of-frame, which clears it to 3'd0.
- R9: `tx_dir` is 1 for ACK_TX_SYMS×CYC_PER_SYM cycles starting with the `ack_start` cycle, after which a one-cycle `irq_tx_end` pulse appears, `tx_dir` returns to 0 and the block listens again.
- R10: After reset, `rx_busy`, `tx_dir`, `ack_start`, both interrupts and `status` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sfd_det | input | 1 | Start-of-frame delimiter detected (one-cycle strobe) |
| frame_end | input | 1 | Last symbol of the frame received (one-cycle strobe) |
| ack_req | input | 1 | ACK-request bit of the received frame |
| frame_type | input | 3 | Frame type field of the received frame |
| short_tat | input | 1 | 1 selects the short turnaround |
| slotted | input | 1 | 1 makes the host trigger start the acknowledgment |
| slp_tr | input | 1 | Host trigger pin, synchronous to clk |
| rx_busy | output | 1 | Frame reception in progress |
| tx_dir | output | 1 | Radio direction, 1 = transmit |
| ack_start | output | 1 | One-cycle pulse that starts the ACK frame |
| irq_rx_end | output | 1 | Receive-end interrupt pulse |
| irq_tx_end | output | 1 | Transmit-end interrupt pulse |
| status | output | 3 | 0 success, 1 waiting for trigger, 7 invalid trigger |

## Verification
The main function is driven with eligible data and command frames under the long and the short turnaround. These runs separate the two timer loads to the exact cycle and show that the transmit window and transmit-end interrupt follow the same way in both. Frames without an ACK request and frames of an ineligible type run with the same timing and must leave the transmitter idle, which separates the filter from the timer path. A slotted frame is left waiting well past both timer lengths before its trigger, which shows the timer is not used in that mode. A trigger pulse while listening separates the invalid status code from the waiting code and tests that a new frame clears it.

// File: rtl/ackseq_pkg.sv
package ackseq_pkg;

    typedef enum logic [2:0] {
        ST_LISTEN    = 3'd0,
        ST_BUSY_RX   = 3'd1,
        ST_ACK_WAIT  = 3'd2,
        ST_SLOT_WAIT = 3'd3,
        ST_ACK_TX    = 3'd4
    } seq_state_e;

    typedef enum logic [2:0] {
        STS_OK        = 3'd0,
        STS_SLOT_WAIT = 3'd1,
        STS_INVALID   = 3'd7
    } seq_status_e;

    typedef struct packed {
        logic rx_end;
        logic tx_end;
        logic ack_go;
    } seq_evt_t;

    localparam logic [2:0] FT_DATA = 3'b001;
    localparam logic [2:0] FT_CMD  = 3'b011;

    function automatic logic ack_eligible(input logic req, input logic [2:0] ftype);
        return req && ((ftype == FT_DATA) || (ftype == FT_CMD));
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sym_prescaler.sv
module sym_prescaler #(
    parameter int CYC_PER_SYM = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int PW = $clog2(CYC_PER_SYM + 1);
    localparam logic [PW-1:0] LAST = PW'(CYC_PER_SYM - 1);

    logic [PW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    assert_presc_range_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/sym_countdown.sv
module sym_countdown #(
    parameter int MAX_SYMS = 22
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           load,
    input  logic [$clog2(MAX_SYMS+1)-1:0]  load_syms,
    input  logic                           tick,
    output logic                           done
);
    localparam int CW = $clog2(MAX_SYMS + 1);

    logic [CW-1:0] cnt;

    assign done = tick && (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst)                        cnt <= '0;
        else if (load)                  cnt <= load_syms;
        else if (tick && cnt != '0)     cnt <= cnt - 1'b1;
    end

    assert_load_takes_R5: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_syms)));

    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/trig_edge.sv
module trig_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= pin;
    end

    assign rise = pin && !prev;

endmodule

// File: rtl/ack_rx_sequencer.sv
module ack_rx_sequencer
    import ackseq_pkg::*;
#(
    parameter int CYC_PER_SYM = 16,
    parameter int LONG_SYMS   = 12,
    parameter int SHORT_SYMS  = 2,
    parameter int ACK_TX_SYMS = 22
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sfd_det,
    input  logic       frame_end,
    input  logic       ack_req,
    input  logic [2:0] frame_type,
    input  logic       short_tat,
    input  logic       slotted,
    input  logic       slp_tr,
    output logic       rx_busy,
    output logic       tx_dir,
    output logic       ack_start,
    output logic       irq_rx_end,
    output logic       irq_tx_end,
    output logic [2:0] status
);
    localparam int MAX_SYMS = max3(LONG_SYMS, SHORT_SYMS, ACK_TX_SYMS);
    localparam int CW       = $clog2(MAX_SYMS + 1);

    seq_state_e  state_q, state_d;
    seq_status_e sts_q, sts_d;
    seq_evt_t    evt_d, evt_q;

    logic          tmr_load;
    logic [CW-1:0] tmr_syms;
    logic          sym_tick;
    logic          tmr_done;
    logic          trig_rise;

    sym_prescaler #(.CYC_PER_SYM(CYC_PER_SYM)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_load),
        .tick    (sym_tick)
    );

    sym_countdown #(.MAX_SYMS(MAX_SYMS)) u_cdown (
        .clk       (clk),
        .rst       (rst),
        .load      (tmr_load),
        .load_syms (tmr_syms),
        .tick      (sym_tick),
        .done      (tmr_done)
    );

    trig_edge u_trig (
        .clk  (clk),
        .rst  (rst),
        .pin  (slp_tr),
        .rise (trig_rise)
    );

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_syms = '0;
        evt_d    = '0;
        unique case (state_q)
            ST_LISTEN: begin
                if (sfd_det) state_d = ST_BUSY_RX;
            end
            ST_BUSY_RX: begin
                if (frame_end) begin
                    evt_d.rx_end = 1'b1;
                    if (!ack_eligible(ack_req, frame_type)) begin
                        state_d = ST_LISTEN;
                    end else if (slotted) begin
                        state_d = ST_SLOT_WAIT;
                    end else begin
                        state_d  = ST_ACK_WAIT;
                        tmr_load = 1'b1;
                        tmr_syms = short_tat ? CW'(SHORT_SYMS) : CW'(LONG_SYMS);
                    end
                end
            end
            ST_ACK_WAIT: begin
                if (tmr_done) begin
                    state_d      = ST_ACK_TX;
                    tmr_load     = 1'b1;
                    tmr_syms     = CW'(ACK_TX_SYMS);
                    evt_d.ack_go = 1'b1;
                end
            end
            ST_SLOT_WAIT: begin
                if (trig_rise) begin
                    state_d      = ST_ACK_TX;
                    tmr_load     = 1'b1;
                    tmr_syms     = CW'(ACK_TX_SYMS);
                    evt_d.ack_go = 1'b1;
                end
            end
            ST_ACK_TX: begin
                if (tmr_done) begin
                    state_d      = ST_LISTEN;
                    evt_d.tx_end = 1'b1;
                end
            end
            default: state_d = ST_LISTEN;
        endcase
    end

    always_comb begin
        sts_d = sts_q;
        if (state_q == ST_LISTEN && sfd_det)         sts_d = STS_OK;
        if (state_d == ST_SLOT_WAIT && state_q != ST_SLOT_WAIT)
                                                     sts_d = STS_SLOT_WAIT;
        if (state_q == ST_SLOT_WAIT && trig_rise)    sts_d = STS_OK;
        if (state_q != ST_SLOT_WAIT && trig_rise)    sts_d = STS_INVALID;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LISTEN;
            sts_q   <= STS_OK;
            evt_q   <= '0;
        end else begin
            state_q <= state_d;
            sts_q   <= sts_d;
            evt_q   <= evt_d;
        end
    end

    assign rx_busy    = (state_q == ST_BUSY_RX);
    assign tx_dir     = (state_q == ST_ACK_TX);
    assign ack_start  = evt_q.ack_go;
    assign irq_rx_end = evt_q.rx_end;
    assign irq_tx_end = evt_q.tx_end;
    assign status     = sts_q;

    assert_sfd_busy_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LISTEN && sfd_det) |=> rx_busy);

    assert_rx_irq_R2: assert property (@(posedge clk) disable iff (rst)
        (rx_busy && frame_end) |=> irq_rx_end);

    assert_filter_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_busy && frame_end && !ack_eligible(ack_req, frame_type)) |=> (state_q == ST_LISTEN));

    assert_start_dir_R9: assert property (@(posedge clk) disable iff (rst)
        ack_start |-> tx_dir);

    assert_txend_listen_R9: assert property (@(posedge clk) disable iff (rst)
        irq_tx_end |-> ($past(tx_dir) && !tx_dir));

    assert_slot_trigger_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLOT_WAIT && !trig_rise) |=> (state_q == ST_SLOT_WAIT));

    assert_wait_status_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLOT_WAIT) |-> (status == 3'd1));

    assert_bad_trig_R8: assert property (@(posedge clk) disable iff (rst)
        (trig_rise && state_q != ST_SLOT_WAIT) |=> (status == 3'd7));

    assert_one_event_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({irq_rx_end, irq_tx_end, ack_start}));

endmodule

// File: tb/sim_ack_rx_sequencer.sv
module sim_ack_rx_sequencer;

    localparam int C   = 16;
    localparam int LNG = 12;
    localparam int SHT = 2;
    localparam int TXS = 22;

    logic       clk = 1'b0;
    logic       rst;
    logic       sfd_det, frame_end, ack_req, short_tat, slotted, slp_tr;
    logic [2:0] frame_type;
    logic       rx_busy, tx_dir, ack_start, irq_rx_end, irq_tx_end;
    logic [2:0] status;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ack_rx_sequencer #(
        .CYC_PER_SYM(C), .LONG_SYMS(LNG), .SHORT_SYMS(SHT), .ACK_TX_SYMS(TXS)
    ) u0 (
        .clk(clk), .rst(rst), .sfd_det(sfd_det), .frame_end(frame_end),
        .ack_req(ack_req), .frame_type(frame_type), .short_tat(short_tat),
        .slotted(slotted), .slp_tr(slp_tr), .rx_busy(rx_busy), .tx_dir(tx_dir),
        .ack_start(ack_start), .irq_rx_end(irq_rx_end), .irq_tx_end(irq_tx_end),
        .status(status)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_frame();
        sfd_det = 1'b1;
        step();
        sfd_det = 1'b0;
        check(rx_busy == 1'b1, "R1 busy after SFD", int'(rx_busy), 1);
        repeat (3) step();
    endtask

    task automatic end_frame();
        frame_end = 1'b1;
        step();
        frame_end = 1'b0;
        check(irq_rx_end == 1'b1, "R2 rx-end pulse", int'(irq_rx_end), 1);
    endtask

    task automatic wait_tx_end();
        int k = 0;
        int drops = 0;
        while (!irq_tx_end && k < 2000) begin
            if (!tx_dir) drops++;
            step();
            k++;
        end
        check(k == TXS * C, "R9 transmit window length", k, TXS * C);
        check(drops == 0, "R9 tx_dir held during ACK", drops, 0);
        check(!tx_dir && !rx_busy, "R9 back to listening", int'(tx_dir), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; sfd_det = 0; frame_end = 0; ack_req = 0; frame_type = 3'b000;
        short_tat = 0; slotted = 0; slp_tr = 0;
        repeat (3) step();
        rst = 1'b0;
        step();
        check({rx_busy, tx_dir, ack_start, irq_rx_end, irq_tx_end} == 5'b0,
              "R10 reset outputs", int'({rx_busy, tx_dir, ack_start, irq_rx_end, irq_tx_end}), 0);
        check(status == 3'd0, "R10 reset status", int'(status), 0);
    endtask

    task automatic t_timed_ack(input logic shrt, input logic [2:0] ft, input int exp_k, input string req);
        int k = 0;
        ack_req = 1'b1; frame_type = ft; short_tat = shrt; slotted = 1'b0;
        start_frame();
        end_frame();
        while (!ack_start && k < 2000) begin
            step();
            k++;
        end
        check(k == exp_k, req, k, exp_k);
        check(tx_dir == 1'b1, "R9 tx_dir with ack_start", int'(tx_dir), 1);
        wait_tx_end();
    endtask

    task automatic t_no_ack(input logic req_bit, input logic [2:0] ft);
        int seen = 0;
        ack_req = req_bit; frame_type = ft; short_tat = 1'b0; slotted = 1'b0;
        start_frame();
        end_frame();
        for (int i = 0; i < (LNG + TXS) * C + 20; i++) begin
            if (ack_start || tx_dir) seen++;
            step();
        end
        check(seen == 0, "R3 no ACK for ineligible frame", seen, 0);
        check(!rx_busy, "R3 back to listening", int'(rx_busy), 0);
    endtask

    task automatic t_stray_end();
        frame_end = 1'b1;
        step();
        frame_end = 1'b0;
        check(irq_rx_end == 1'b0, "R2 no pulse while listening", int'(irq_rx_end), 0);
    endtask

    task automatic t_slotted();
        int seen = 0;
        ack_req = 1'b1; frame_type = 3'b001; short_tat = 1'b1; slotted = 1'b1;
        start_frame();
        end_frame();
        check(status == 3'd1, "R7 waiting status", int'(status), 1);
        for (int i = 0; i < (LNG + 4) * C; i++) begin
            if (ack_start || tx_dir) seen++;
            step();
        end
        check(seen == 0, "R6 timer ignored in slotted mode", seen, 0);
        check(status == 3'd1, "R7 still waiting", int'(status), 1);
        slp_tr = 1'b1;
        step();
        check(ack_start == 1'b1, "R6 ACK on trigger rise", int'(ack_start), 1);
        check(status == 3'd0, "R7 success after trigger", int'(status), 0);
        slp_tr = 1'b0;
        wait_tx_end();
        slotted = 1'b0;
    endtask

    task automatic t_bad_trigger();
        slp_tr = 1'b1;
        step();
        slp_tr = 1'b0;
        check(status == 3'd7, "R8 invalid trigger status", int'(status), 7);
        repeat (5) step();
        check(status == 3'd7, "R8 invalid status held", int'(status), 7);
        ack_req = 1'b0;
        start_frame();
        check(status == 3'd0, "R8 cleared by SFD", int'(status), 0);
        end_frame();
        step();
    endtask

    initial begin
        wait (cyc >= 150000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        sfd_det = 0; frame_end = 0; ack_req = 0; frame_type = 3'b000;
        short_tat = 0; slotted = 0; slp_tr = 0;
        @(negedge clk);
        t_reset();
        t_timed_ack(1'b0, 3'b001, LNG * C, "R4 long turnaround data");
        t_timed_ack(1'b1, 3'b011, SHT * C, "R5 short turnaround command");
        t_timed_ack(1'b0, 3'b011, LNG * C, "R4 long turnaround command");
        t_no_ack(1'b0, 3'b001);
        t_no_ack(1'b1, 3'b000);
        t_no_ack(1'b1, 3'b010);
        t_stray_end();
        t_slotted();
        t_bad_trigger();
        t_timed_ack(1'b1, 3'b001, SHT * C, "R5 short turnaround data");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule